// File: doc/BRIEF.md
# Averaged Input Undervoltage Flag

This block watches an averaged input-voltage reading, which arrives once per averaging window with a one-cycle valid strobe. Only the upper nibble of each accepted reading is compared with a 4-bit coarse threshold. A reading whose upper nibble is strictly smaller than the threshold counts as an undervoltage sample. The block then qualifies this condition with two independent debounce timers. Both timers count a 100 µs time-base tick that enters as a single-cycle pulse.

The main timer drives the undervoltage flag. A 2-bit selector sets its interval to none, 2.6 ms, 10.4 ms or 100 ms. The second timer drives the block's contribution to a power-good output. Its interval is either none or 2.6 ms. An enable input gates this contribution onto its own output. Each timer applies the same interval in both directions, to set and to clear its result. A timer restarts from zero whenever its condition matches its current state, when the threshold changes, and when its own selector changes.

Top module: `uvf_avg_uv_mon`

## Requirements
- R1: An accepted reading is undervoltage when its bits [7:4], read as an unsigned number, are less than the threshold. Bits [3:0] have no effect. A nibble equal to the threshold is not undervoltage, and a threshold of 0 never flags.
- R2: The stored reading changes only in a cycle where smp_valid_i is high. Data present without the strobe is ignored.
- R3: uv_dbn_sel_i encodes the main interval: 0 means none, 1 means 26 ticks, 2 means 104 ticks and 3 means 1000 ticks. With 0, the flag follows the condition two clock edges after the strobe. With the others, the flag sets on the clock edge that accepts the N-th tick counted while the condition differs from the flag.
- R4: A non-undervoltage reading that arrives before the interval expires restarts the set timer from zero.
- R5: The flag clears only after the condition has been absent for the same number of ticks as the set interval.
- R6: A change of the threshold, or of a timer's own selector, restarts that timer from zero.
- R7: pg_uv_o equals pg_inc_en_i AND the power-good debounced state. pg_dbn_sel_i = 0 gives no debounce and 1 gives 26 ticks, independent of the main interval.
- R8: After reset both outputs are 0, and the stored reading is all ones, so it is not undervoltage for any threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every 100 µs |
| smp_valid_i | input | 1 | Strobe for a new averaged reading |
| smp_data_i | input | 8 | Averaged reading |
| uv_thr_i | input | 4 | Coarse threshold for the upper nibble |
| uv_dbn_sel_i | input | 2 | Main debounce selector |
| pg_inc_en_i | input | 1 | Include condition in power-good |
| pg_dbn_sel_i | input | 1 | Power-good debounce selector |
| uv_flag_o | output | 1 | Debounced undervoltage flag |
| pg_uv_o | output | 1 | Power-good undervoltage contribution |

## Verification
With no debounce, a reading strobed at one clock edge is captured at that edge, and the flag moves at the next edge. The bench therefore checks it at the third falling edge after driving the strobe. A threshold change delays that by one cycle at most, and the third falling edge still covers it. For the debounced intervals, every tick is a one-cycle pulse driven at a falling edge. The bench checks the output at the falling edge after the N-1-th tick, where it must still hold, and again after the N-th tick, where it must have changed. The gate on pg_uv_o is combinational, so it is checked one cycle after the enable is driven.

// File: rtl/uvf_pkg.sv
package uvf_pkg;
   typedef enum logic [1:0] {
      DBN_NONE  = 2'd0,
      DBN_SHORT = 2'd1,
      DBN_MID   = 2'd2,
      DBN_LONG  = 2'd3
   } dbn_sel_e;
endpackage

// File: rtl/uvf_level_cmp.sv
module uvf_level_cmp #(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned THR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid_i,
   input  logic [SMP_W-1:0] smp_data_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             below_o
);
   localparam int unsigned TOP_LSB = SMP_W - THR_W;

   logic [THR_W-1:0] nib_q;

   // reset value: full scale, never below any threshold (R8)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           nib_q <= '1;
      else if (smp_valid_i) nib_q <= smp_data_i[SMP_W-1:TOP_LSB];
   end

   assign below_o = (nib_q < thr_i);

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_i |=> (nib_q == $past(smp_data_i[SMP_W-1:TOP_LSB])));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid_i |=> $stable(nib_q));
endmodule

// File: rtl/uvf_debounce.sv
module uvf_debounce #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] term_i,
   input  logic             cond_i,
   output logic             state_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             state_q;
   logic             last_tick;

   assign last_tick = (cnt_q == term_i - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         state_q <= 1'b0;
      end else if (restart_i || (cond_i == state_q)) begin
         cnt_q <= '0;
      end else if (term_i == '0) begin
         state_q <= cond_i;
      end else if (tick_i) begin
         if (last_tick) begin
            state_q <= cond_i;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign state_o = state_q;

   a_r3_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != $past(state_q)) |-> ($past(tick_i) || ($past(term_i) == '0)));
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && (term_i != '0)) |-> (cnt_q < term_i));
   a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == state_q) |=> (cnt_q == '0));
   a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/uvf_avg_uv_mon.sv
module uvf_avg_uv_mon #(
   parameter int unsigned SMP_W      = 8,
   parameter int unsigned THR_W      = 4,
   parameter int unsigned T_SHORT    = 26,
   parameter int unsigned T_MID      = 104,
   parameter int unsigned T_LONG     = 1000,
   parameter int unsigned T_PG       = 26,
   parameter bit          PG_PATH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             smp_valid_i,
   input  logic [SMP_W-1:0] smp_data_i,
   input  logic [THR_W-1:0] uv_thr_i,
   input  logic [1:0]       uv_dbn_sel_i,
   input  logic             pg_inc_en_i,
   input  logic             pg_dbn_sel_i,
   output logic             uv_flag_o,
   output logic             pg_uv_o
);
   import uvf_pkg::*;

   localparam int unsigned CNT_W = $clog2(T_LONG + 1);

   if (THR_W > SMP_W) begin : g_bad_width
      $error("threshold wider than sample");
   end
   if (!(T_SHORT <= T_MID && T_MID <= T_LONG && T_PG <= T_LONG)) begin : g_bad_terms
      $error("debounce terminal counts out of order");
   end

   logic             below;
   logic [THR_W-1:0] thr_q;
   logic [1:0]       sel_q;
   logic             pg_sel_q;
   logic             thr_chg;
   logic [CNT_W-1:0] main_term;
   logic             main_state;

   uvf_level_cmp #(.SMP_W(SMP_W), .THR_W(THR_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid_i(smp_valid_i),
      .smp_data_i (smp_data_i),
      .thr_i      (uv_thr_i),
      .below_o    (below)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q    <= '0;
         sel_q    <= '0;
         pg_sel_q <= 1'b0;
      end else begin
         thr_q    <= uv_thr_i;
         sel_q    <= uv_dbn_sel_i;
         pg_sel_q <= pg_dbn_sel_i;
      end
   end

   assign thr_chg = (thr_q != uv_thr_i);

   always_comb begin
      case (dbn_sel_e'(uv_dbn_sel_i))
         DBN_SHORT: main_term = CNT_W'(T_SHORT);
         DBN_MID:   main_term = CNT_W'(T_MID);
         DBN_LONG:  main_term = CNT_W'(T_LONG);
         default:   main_term = '0;
      endcase
   end

   uvf_debounce #(.CNT_W(CNT_W)) u_main_dbn (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .restart_i(thr_chg || (sel_q != uv_dbn_sel_i)),
      .term_i   (main_term),
      .cond_i   (below),
      .state_o  (main_state)
   );

   assign uv_flag_o = main_state;

   if (PG_PATH_EN) begin : g_pg
      logic [CNT_W-1:0] pg_term;
      logic             pg_state;

      assign pg_term = pg_dbn_sel_i ? CNT_W'(T_PG) : '0;

      uvf_debounce #(.CNT_W(CNT_W)) u_pg_dbn (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_i   (tick_i),
         .restart_i(thr_chg || (pg_sel_q != pg_dbn_sel_i)),
         .term_i   (pg_term),
         .cond_i   (below),
         .state_o  (pg_state)
      );

      assign pg_uv_o = pg_inc_en_i & pg_state;
   end else begin : g_no_pg
      assign pg_uv_o = 1'b0;
   end

   a_r1_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_flag_o) |-> $past(below));
   a_r5_fall_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(uv_flag_o) |-> !$past(below));
endmodule

// File: tb/uvf_avg_uv_mon_tb_top.sv
module uvf_avg_uv_mon_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       valid = 1'b0;
   logic [7:0] smp = 8'hFF;
   logic [3:0] thr = 4'd8;
   logic [1:0] sel = 2'd0;
   logic       pg_en = 1'b0;
   logic       pg_sel = 1'b0;
   logic       uv_flag;
   logic       pg_uv;
   int         checks = 0;
   int         errors = 0;

   always #2.5 clk = ~clk;

   uvf_avg_uv_mon dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .smp_valid_i(valid),
      .smp_data_i(smp), .uv_thr_i(thr), .uv_dbn_sel_i(sel),
      .pg_inc_en_i(pg_en), .pg_dbn_sel_i(pg_sel),
      .uv_flag_o(uv_flag), .pg_uv_o(pg_uv)
   );

   function automatic logic exp_uv(input logic [7:0] s, input logic [3:0] t);
      return (s[7:4] < t);
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         tick = 1'b1; @(negedge clk);
         tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic put(input logic [7:0] s);
      smp = s; valid = 1'b1; @(negedge clk);
      valid = 1'b0; cyc(2);
   endtask

   task automatic dbn_run(input logic [1:0] s, input int term);
      sel = 2'd0; thr = 4'd8; put(8'hF0); cyc(1);
      sel = s; cyc(2);
      put(8'h2F);                             // R3 set path
      ticks(term - 1); chk("R3 hold before set", uv_flag, 1'b0);
      ticks(1);        chk("R3 set at terminal", uv_flag, 1'b1);
      put(8'h90);                             // R5 clear path
      ticks(term - 1); chk("R5 hold before clear", uv_flag, 1'b1);
      ticks(1);        chk("R5 clear at terminal", uv_flag, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rs;
      logic [3:0] rt;
      logic       re;
      void'($urandom(32'd1234));
      cyc(3);
      chk("R8 reset flag", uv_flag, 1'b0);
      chk("R8 reset pg", pg_uv, 1'b0);
      rst_n = 1'b1; cyc(2);
      put(8'h00);                             // no strobe yet seen: stored full scale
      thr = 4'd15; pg_en = 1'b1; cyc(1);
      // R8: after the put above 0x00 < 15 flags; check the reset value via a fresh reset
      rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(3);
      chk("R8 stored full scale at thr 15", uv_flag, 1'b0);

      // R1 boundaries, no debounce
      thr = 4'd5; put(8'h5F); chk("R1 equal nibble not uv", uv_flag, 1'b0);
      put(8'h40); chk("R1 nibble below thr", uv_flag, 1'b1);
      put(8'h5F); chk("R1 low bits ignored", uv_flag, 1'b0);
      thr = 4'd0; put(8'h00); chk("R1 thr zero never flags", uv_flag, 1'b0);

      // R2: data without strobe ignored
      thr = 4'd8; put(8'hA0); chk("R2 setup", uv_flag, 1'b0);
      smp = 8'h00; cyc(4); chk("R2 no strobe no change", uv_flag, 1'b0);

      // R1/R7 random, both debounces off
      for (int i = 0; i < 40; i++) begin
         rs = 8'($urandom); rt = 4'($urandom); re = 1'($urandom);
         thr = rt; pg_en = re; put(rs);
         chk("R1 random flag", uv_flag, exp_uv(rs, rt));
         chk("R7 random pg", pg_uv, re & exp_uv(rs, rt));
      end

      pg_en = 1'b0;
      dbn_run(2'd1, 26);
      dbn_run(2'd2, 104);
      dbn_run(2'd3, 1000);

      // R4: interruption restarts set timer
      sel = 2'd0; thr = 4'd8; put(8'hF0); sel = 2'd1; cyc(2);
      put(8'h20); ticks(20); put(8'hC0); put(8'h20);
      ticks(20); chk("R4 restart after ok sample", uv_flag, 1'b0);
      ticks(6);  chk("R4 set after full interval", uv_flag, 1'b1);

      // R6: threshold change restarts timer
      sel = 2'd0; put(8'hF0); sel = 2'd1; cyc(2);
      put(8'h2F); ticks(20); thr = 4'd6; cyc(2);
      ticks(20); chk("R6 thr change restarts", uv_flag, 1'b0);
      ticks(6);  chk("R6 set after restart", uv_flag, 1'b1);
      // R6: selector change restarts clear timer
      put(8'hF0); ticks(20); sel = 2'd2; cyc(2);
      ticks(103); chk("R6 sel change restarts", uv_flag, 1'b1);
      ticks(1);   chk("R6 clear at new terminal", uv_flag, 1'b0);

      // R7: separate power-good timer
      thr = 4'd8; sel = 2'd3; pg_sel = 1'b1; pg_en = 1'b1; cyc(2);
      put(8'h10);
      ticks(25); chk("R7 pg hold", pg_uv, 1'b0);
      ticks(1);  chk("R7 pg set at 26", pg_uv, 1'b1);
      chk("R7 main flag independent", uv_flag, 1'b0);
      pg_en = 1'b0; cyc(1); chk("R7 pg gated off", pg_uv, 1'b0);
      pg_en = 1'b1; cyc(1); chk("R7 pg gated on", pg_uv, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule